// File: doc/BRIEF.md
# I2C GPIO Expander Register Target

This block is an I2C target that gives a host sixteen general-purpose pins through eight byte-wide registers. The registers come in four pairs, each pair covering the low and high byte of the pins: the live pin levels (read only, polarity-adjusted), the stored output values, a per-bit polarity inversion mask and a per-bit direction setting. The block takes already-synchronised SCL and SDA levels, drives SDA through an open-drain enable, and drives an output enable and an output value for every pin.

A transfer begins with the 7-bit address. After a write address the first byte is a command that sets a register pointer, and each following byte is written to the register the pointer selects. Reads use a repeated START after the command, then the address with the read bit set. After every data byte, read or written, the pointer flips to the other register of the same pair instead of counting upward, so a long transfer alternates between the two bytes of one register pair.

Two address-select inputs supply the low address bits so that four of these targets can share a bus. An active-low reset holds every register and the bus state machine at its default for as long as it is low.

Top module: `gpx_expander`

## Requirements
- R1: The target acknowledges (drives SDA low in the ninth clock) only an address byte whose upper seven bits equal 1110 1, addr_sel[1], addr_sel[0]; any other address gets no acknowledge, and the data that follows changes no register.
- R2: The first byte after a matching address with bit 0 = 0 is a command whose bits [2:0] select register 0 to 7 (0/1 input, 2/3 output, 4/5 polarity, 6/7 direction; the odd number is the high pin byte, pins 15..8) and it is acknowledged.
- R3: After each data byte, written or read, the pointer bit 0 inverts and bits [2:1] stay, so any number of bytes alternates between the two registers of one pair (3, 2, 3, ...).
- R4: Reading register 0 or 1 returns the pin levels of that byte XOR the matching polarity byte, whatever the pin direction; writes to registers 0 and 1 change nothing.
- R5: Reading register 2 or 3 returns the stored output byte, not the pin level; pin_o always equals the stored output bytes {reg3, reg2}.
- R6: A 1 in direction register 6/7 makes the pin an input (pin_oe bit 0); a 0 makes it an output (pin_oe bit 1).
- R7: A read is a command write, a repeated START, and the address with bit 0 = 1; data leaves MSB first, the target continues while the master acknowledges and releases SDA after the master's NACK.
- R8: While rst_n is low the output bytes are FF, the polarity bytes 00, the direction bytes FF (all pins inputs), the pointer 0 and SDA released; they stay so until release.
- R9: A STOP releases SDA and returns the target to idle; a START at any point restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 2 | Low two address bits |
| pin_i | input | 16 | Pin levels |
| pin_oe | output | 16 | Per-pin drive enable, 1 = output |
| pin_o | output | 16 | Per-pin drive value |

## Verification
On every cycle the assertions check that a STOP releases SDA, that data-byte strobes are single-cycle, that the pointer stays inside its pair when it advances, that a write aimed at the input pair leaves every stored register alone, that the read bit on SDA holds steady between SCL falls, and that all pins come out of reset as inputs with outputs high. Only the bench's scenarios can show the address match against all 128 addresses, the alternating pair order over multi-byte reads and writes, the polarity-adjusted input values over several pin and mask patterns, and the register contents after a mid-run reset, since these need whole bus transactions and expected values built from them.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int BYTE_W    = 8;
    localparam int NPORT     = 2;
    localparam int GPIO_W    = BYTE_W * NPORT;
    localparam int REG_IDX_W = 3;
    localparam int CNT_W     = 4;

    localparam logic [1:0] KIND_IN  = 2'd0;
    localparam logic [1:0] KIND_OUT = 2'd1;
    localparam logic [1:0] KIND_POL = 2'd2;
    localparam logic [1:0] KIND_CFG = 2'd3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } link_st_e;

    typedef struct packed {
        link_st_e          st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              rw;
        logic              mack;
    } link_s;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_s;
endpackage

// File: rtl/gpx_line_events.sv
module gpx_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    import gpx_pkg::*;

    line_s line_d, line_q;

    always_comb begin
        line_d     = line_q;
        line_d.scl = scl_i;
        line_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            line_q <= line_d;
        end
    end

    assign scl_rise  = !line_q.scl && scl_i;
    assign scl_fall  = line_q.scl && !scl_i;
    assign bus_start = line_q.scl && scl_i && line_q.sda && !sda_i;
    assign bus_stop  = line_q.scl && scl_i && !line_q.sda && sda_i;
endmodule

// File: rtl/gpx_link_fsm.sv
module gpx_link_fsm #(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              sda_i,
    input  logic [BYTE_W-2:0] dev_addr,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic              ptr_load,
    output logic [IDX_W-1:0]  ptr_val,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              ptr_adv
);
    import gpx_pkg::*;

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_RD  = CNT_W'(BYTE_W - 1);

    link_s lk_d, lk_q;
    logic  shifting;

    assign shifting = (lk_q.st == ST_ADDR) || (lk_q.st == ST_CMD) || (lk_q.st == ST_WR);

    always_comb begin
        lk_d     = lk_q;
        ptr_load = 1'b0;
        wr_en    = 1'b0;
        ptr_adv  = 1'b0;
        ptr_val  = lk_q.sh[IDX_W-1:0];
        wr_byte  = lk_q.sh;
        if (bus_stop) begin
            lk_d.st = ST_IDLE;
        end else if (bus_start) begin
            lk_d.st  = ST_ADDR;
            lk_d.cnt = '0;
        end else if (shifting && scl_rise && lk_q.cnt < FULL_CNT) begin
            lk_d.sh  = {lk_q.sh[BYTE_W-2:0], sda_i};
            lk_d.cnt = lk_q.cnt + 1'b1;
        end else if (shifting && scl_fall && lk_q.cnt == FULL_CNT) begin
            unique case (lk_q.st)
                ST_ADDR: begin
                    if (lk_q.sh[BYTE_W-1:1] == dev_addr) begin
                        lk_d.st = ST_ADDR_ACK;
                        lk_d.rw = lk_q.sh[0];
                    end else begin
                        lk_d.st = ST_IDLE;
                    end
                end
                ST_CMD: begin
                    ptr_load = 1'b1;
                    lk_d.st  = ST_CMD_ACK;
                end
                default: begin
                    wr_en   = 1'b1;
                    ptr_adv = 1'b1;
                    lk_d.st = ST_WR_ACK;
                end
            endcase
        end else begin
            unique case (lk_q.st)
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        lk_d.cnt = '0;
                        if (lk_q.rw) begin
                            lk_d.st = ST_RD;
                            lk_d.sh = rd_byte;
                        end else begin
                            lk_d.st = ST_CMD;
                        end
                    end
                end
                ST_CMD_ACK, ST_WR_ACK: begin
                    if (scl_fall) begin
                        lk_d.st  = ST_WR;
                        lk_d.cnt = '0;
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (lk_q.cnt == LAST_RD) begin
                            lk_d.st = ST_RD_ACK;
                            ptr_adv = 1'b1;
                        end else begin
                            lk_d.sh  = {lk_q.sh[BYTE_W-2:0], 1'b0};
                            lk_d.cnt = lk_q.cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        lk_d.mack = !sda_i;
                    end else if (scl_fall) begin
                        if (lk_q.mack) begin
                            lk_d.st  = ST_RD;
                            lk_d.sh  = rd_byte;
                            lk_d.cnt = '0;
                        end else begin
                            lk_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= '{st: ST_IDLE, cnt: '0, sh: '0, rw: 1'b0, mack: 1'b0};
        end else begin
            lk_q <= lk_d;
        end
    end

    assign sda_oe = (lk_q.st == ST_ADDR_ACK) || (lk_q.st == ST_CMD_ACK) ||
                    (lk_q.st == ST_WR_ACK) || ((lk_q.st == ST_RD) && !lk_q.sh[BYTE_W-1]);

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !sda_oe);

    // R3
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R3
    adv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_adv |=> !ptr_adv);

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q.st == ST_RD && $past(lk_q.st) == ST_RD && !$past(scl_fall)) |-> $stable(sda_oe));
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile #(
    parameter int BYTE_W = 8,
    parameter int NPORT  = 2,
    parameter int IDX_W  = 3,
    localparam int GPIO_W = BYTE_W * NPORT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GPIO_W-1:0] pin_i,
    input  logic              ptr_load,
    input  logic [IDX_W-1:0]  ptr_val,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              ptr_adv,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [GPIO_W-1:0] pin_oe,
    output logic [GPIO_W-1:0] pin_o
);
    import gpx_pkg::*;

    typedef struct packed {
        logic [NPORT-1:0][BYTE_W-1:0] outv;
        logic [NPORT-1:0][BYTE_W-1:0] pol;
        logic [NPORT-1:0][BYTE_W-1:0] cfg;
        logic [IDX_W-1:0]             ptr;
    } regs_s;

    regs_s rg_d, rg_q;

    logic [1:0]                   kind;
    logic                         port;
    logic [NPORT-1:0][BYTE_W-1:0] in_adj;

    assign kind = rg_q.ptr[IDX_W-1:1];
    assign port = rg_q.ptr[0];

    for (genvar p = 0; p < NPORT; p++) begin : g_in
        assign in_adj[p] = pin_i[p*BYTE_W +: BYTE_W] ^ rg_q.pol[p];
    end

    always_comb begin
        unique case (kind)
            KIND_IN:  rd_byte = in_adj[port];
            KIND_OUT: rd_byte = rg_q.outv[port];
            KIND_POL: rd_byte = rg_q.pol[port];
            default:  rd_byte = rg_q.cfg[port];
        endcase
    end

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            unique case (kind)
                KIND_OUT: rg_d.outv[port] = wr_byte;
                KIND_POL: rg_d.pol[port]  = wr_byte;
                KIND_CFG: rg_d.cfg[port]  = wr_byte;
                default: ;
            endcase
        end
        if (ptr_load) begin
            rg_d.ptr = ptr_val;
        end else if (ptr_adv) begin
            rg_d.ptr[0] = !rg_q.ptr[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '{outv: '1, pol: '0, cfg: '1, ptr: '0};
        end else begin
            rg_q <= rg_d;
        end
    end

    assign pin_oe = ~rg_q.cfg;
    assign pin_o  = rg_q.outv;

    // R4
    in_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == KIND_IN) |=> ($stable(rg_q.outv) && $stable(rg_q.pol) && $stable(rg_q.cfg)));

    // R3
    ptr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_adv && !ptr_load) |=> (rg_q.ptr[IDX_W-1:1] == $past(rg_q.ptr[IDX_W-1:1]) &&
                                    rg_q.ptr[0] != $past(rg_q.ptr[0])));

    // R8
    reset_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_o == '1));
endmodule

// File: rtl/gpx_expander.sv
module gpx_expander #(
    parameter logic [4:0] DEV_PREFIX = 5'b11101
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [1:0]  addr_sel,
    input  logic [15:0] pin_i,
    output logic [15:0] pin_oe,
    output logic [15:0] pin_o
);
    import gpx_pkg::*;

    logic                 scl_rise, scl_fall, bus_start, bus_stop;
    logic                 ptr_load, wr_en, ptr_adv;
    logic [REG_IDX_W-1:0] ptr_val;
    logic [BYTE_W-1:0]    wr_byte, rd_byte;
    logic [BYTE_W-2:0]    dev_addr;

    assign dev_addr = {DEV_PREFIX, addr_sel};

    gpx_line_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    gpx_link_fsm #(.BYTE_W(BYTE_W), .IDX_W(REG_IDX_W)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .sda_i     (sda_i),
        .dev_addr  (dev_addr),
        .rd_byte   (rd_byte),
        .sda_oe    (sda_oe),
        .ptr_load  (ptr_load),
        .ptr_val   (ptr_val),
        .wr_en     (wr_en),
        .wr_byte   (wr_byte),
        .ptr_adv   (ptr_adv)
    );

    gpx_regfile #(.BYTE_W(BYTE_W), .NPORT(NPORT), .IDX_W(REG_IDX_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (pin_i),
        .ptr_load (ptr_load),
        .ptr_val  (ptr_val),
        .wr_en    (wr_en),
        .wr_byte  (wr_byte),
        .ptr_adv  (ptr_adv),
        .rd_byte  (rd_byte),
        .pin_oe   (pin_oe),
        .pin_o    (pin_o)
    );
endmodule

// File: tb/gpx_expander_tb.sv
module gpx_expander_tb;
    localparam int Q = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  addr_sel = 2'b10;
    logic [15:0] pin_i = 16'h0000;
    logic        sda_oe;
    logic [15:0] pin_oe, pin_o;
    logic        sda_bus;
    logic [7:0]  rbuf [4];
    int          nchk = 0;
    int          nerr = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    gpx_expander u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .addr_sel (addr_sel),
        .pin_i    (pin_i),
        .pin_oe   (pin_oe),
        .pin_o    (pin_o)
    );

    function automatic logic [6:0] dev();
        return {5'b11101, addr_sel};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_w(input logic b);
        sda_m = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bit_r(output logic b);
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_bus; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic byte_w(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_w(d[i]);
        bit_r(b);
        ack = !b;
    endtask

    task automatic byte_r(input logic mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            bit_r(b);
            d[i] = b;
        end
        bit_w(!mack);
    endtask

    task automatic write_seq(input logic [7:0] cmd, input int n,
                             input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        logic ack;
        logic [7:0] dd [3];
        dd[0] = d0; dd[1] = d1; dd[2] = d2;
        bus_start();
        byte_w({dev(), 1'b0}, ack); check("R1 address ack", ack, 1);
        byte_w(cmd, ack);           check("R2 command ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            byte_w(dd[i], ack);     check("R3 data ack", ack, 1);
        end
        bus_stop();
        check("R9 sda released after stop", sda_bus, 1);
    endtask

    task automatic read_seq(input logic [7:0] cmd, input int n);
        logic ack;
        bus_start();
        byte_w({dev(), 1'b0}, ack); check("R7 write address ack", ack, 1);
        byte_w(cmd, ack);           check("R7 command ack", ack, 1);
        bus_start();
        byte_w({dev(), 1'b1}, ack); check("R7 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            byte_r(i < n - 1, d);
            rbuf[i] = d;
        end
        tick(2);
        check("R7 sda released after nack", sda_bus, 1);
        bus_stop();
    endtask

    initial begin
        tick(5);
        check("R8 reset pin_oe", pin_oe, 16'h0000);
        check("R8 reset pin_o", pin_o, 16'hFFFF);
        check("R8 reset sda", sda_bus, 1);
        rst_n = 1'b1;
        tick(4);

        // R1: sweep every 7-bit address
        for (int a = 0; a < 128; a++) begin
            logic ack;
            bus_start();
            byte_w({7'(a), 1'b0}, ack);
            bus_stop();
            check("R1 address sweep", ack, (7'(a) == dev()));
        end
        for (int s = 0; s < 4; s++) begin
            logic ack;
            addr_sel = 2'(s);
            bus_start(); byte_w({5'b11101, 2'(s), 1'b0}, ack); bus_stop();
            check("R1 select match", ack, 1);
            bus_start(); byte_w({5'b11101, 2'(s) ^ 2'b01, 1'b0}, ack); bus_stop();
            check("R1 select mismatch", ack, 0);
        end
        addr_sel = 2'b10;

        begin
            logic ack;
            bus_start();
            byte_w({dev() ^ 7'h01, 1'b0}, ack);
            byte_w(8'h02, ack);
            byte_w(8'h00, ack);
            bus_stop();
            check("R1 foreign write leaves pin_o", pin_o, 16'hFFFF);
        end

        // R3: output pair 3,2,3
        write_seq(8'h03, 3, 8'hA5, 8'h3C, 8'h5A);
        check("R3 R5 output toggle", pin_o, 16'h5A3C);

        // R6: direction pair 6,7
        write_seq(8'h06, 2, 8'h00, 8'hF0, 8'h00);
        check("R6 direction", pin_oe, 16'h0FFF);

        // R5: output readback ignores pin levels
        pin_i = 16'h1234;
        read_seq(8'h02, 3);
        check("R5 read reg2", rbuf[0], 8'h3C);
        check("R3 read reg3", rbuf[1], 8'h5A);
        check("R3 read reg2 again", rbuf[2], 8'h3C);

        // R4: writes to input pair ignored
        write_seq(8'h00, 2, 8'h00, 8'h00, 8'h00);
        check("R4 pin_o unchanged", pin_o, 16'h5A3C);
        check("R4 pin_oe unchanged", pin_oe, 16'h0FFF);
        read_seq(8'h04, 2);
        check("R4 pol0 unchanged", rbuf[0], 8'h00);
        check("R4 pol1 unchanged", rbuf[1], 8'h00);
        read_seq(8'h00, 1);
        check("R4 input reads pins", rbuf[0], 8'h34);

        // R4: polarity sweep over mixed directions
        for (int k = 0; k < 8; k++) begin
            logic [15:0] pv, mk;
            pv = 16'(k * 16'h2F13) ^ 16'h8421;
            mk = 16'(k * 16'h1357) ^ 16'hC003;
            pin_i = pv;
            write_seq(8'h05, 2, mk[15:8], mk[7:0], 8'h00);
            read_seq(8'h00, 2);
            check("R4 input byte0", rbuf[0], pv[7:0] ^ mk[7:0]);
            check("R4 input byte1", rbuf[1], pv[15:8] ^ mk[15:8]);
            read_seq(8'h01, 3);
            check("R3 input hi first", rbuf[0], pv[15:8] ^ mk[15:8]);
            check("R3 input lo second", rbuf[1], pv[7:0] ^ mk[7:0]);
            check("R3 input hi third", rbuf[2], pv[15:8] ^ mk[15:8]);
        end

        read_seq(8'h07, 2);
        check("R6 read cfg hi", rbuf[0], 8'hF0);
        check("R6 read cfg lo", rbuf[1], 8'h00);

        // R9: START mid-byte aborts the write
        begin
            logic ack;
            bus_start();
            byte_w({dev(), 1'b0}, ack);
            byte_w(8'h02, ack);
            bit_w(1'b0); bit_w(1'b0); bit_w(1'b0);
            bus_start();
            bus_stop();
            check("R9 aborted write", pin_o, 16'h5A3C);
        end

        // R8: reset in the middle of activity
        rst_n = 1'b0;
        tick(3);
        check("R8 held pin_o", pin_o, 16'hFFFF);
        check("R8 held pin_oe", pin_oe, 16'h0000);
        rst_n = 1'b1;
        tick(3);
        read_seq(8'h04, 2);
        check("R8 pol default lo", rbuf[0], 8'h00);
        check("R8 pol default hi", rbuf[1], 8'h00);
        read_seq(8'h06, 2);
        check("R8 cfg default lo", rbuf[0], 8'hFF);
        check("R8 cfg default hi", rbuf[1], 8'hFF);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule